// File: doc/BRIEF.md
# Length-prefixed serial ID reader

This block hands a device-unique identifier to a host one bit per register read. The identifier arrives as a parallel word, standing in for an on-chip identity primitive. The block captures that word into a shift chain on reset and on each reload request.

The stream begins with an 8-bit field that gives the identifier width, so software can rebuild identifiers of any size without knowing the width in advance. The identifier bits follow. Both parts are sent most significant bit first. Software builds the value by shifting its running result left and adding each read value.

The current bit is shown in bit 0 of an 8-bit read value. A read strobe moves the stream to the next bit at the end of that cycle. When the stream is used up it yields zeros until the next reload.

Top module: `serial_id_reader`

## Requirements
- R1: One clock edge with `rst_n` low is enough to capture `id_in` and place the stream at the first length bit. The stream is at that bit while `rst_n` is still low.
- R2: The first eight bits of the stream carry the identifier width, most significant bit first. With the default 57-bit identifier they read 0,0,1,1,1,0,0,1 (57).
- R3: After the length field come the identifier bits, most significant bit first. The identifier is the `id_in` value captured at the most recent reset or reload.
- R4: Bits 7:1 of `rd_data` are always zero. The current stream bit is in bit 0.
- R5: A clock edge with `rd_i` high and `reload_i` low moves the stream forward by exactly one bit. With neither strobe high, `rd_data` stays the same.
- R6: A clock edge with `reload_i` high captures `id_in` again and returns the stream to the first length bit. This holds even when `rd_i` is high in the same cycle.
- R7: After all 8 + ID_W bits have been read, `rd_data` is zero and stays zero through any number of further reads until a reload.
- R8: Changes on `id_in` between captures have no effect on the bits being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; captures the identifier like a reload |
| id_in | input | ID_W | Parallel device identifier |
| rd_i | input | 1 | Read strobe; moves the stream forward at the clock edge |
| reload_i | input | 1 | Restart strobe; recaptures the identifier and rewinds the stream |
| rd_data | output | 8 | Read value; bit 0 is the current stream bit |

## Verification
The hardest case to reach from the ports is the end of the stream. The host must issue 65 reads with no reload in between. Only then does the zero-fill region appear, and only then can extra reads be shown to have no effect there. The directed part of the stimulus issues full read-outs plus extra reads. The random part keeps reloads rare, so long runs of reads often reach the end.

Other cases are also covered:
- A read and a reload in the same cycle.
- Changes on `id_in` between captures, which the random stimulus makes often.

The bench rebuilds the length and identifier values from full read-outs.

// File: rtl/serial_id_reader.sv
module serial_id_reader #(
  parameter int ID_W  = 57,
  parameter int LEN_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id_in,
  input  logic            rd_i,
  input  logic            reload_i,
  output logic [7:0]      rd_data
);
  localparam int TOT = LEN_W + ID_W;
  localparam int PW  = $clog2(TOT + 1);
  localparam logic [LEN_W-1:0] LEN_VAL = LEN_W'(ID_W);
  localparam logic [PW-1:0]    POS_END = PW'(TOT);

  logic [TOT-1:0] chain;
  logic [PW-1:0]  pos;
  logic           load;

  assign load    = !rst_n || reload_i;
  assign rd_data = {7'b0, chain[TOT-1]};

  always_ff @(posedge clk) begin
    if (load) begin
      chain <= {LEN_VAL, id_in};
      pos   <= '0;
    end else if (rd_i) begin
      chain <= {chain[TOT-2:0], 1'b0};
      if (pos != POS_END) pos <= pos + 1'b1;
    end
  end

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !reload_i) |=> rd_data[0] == $past(chain[TOT-2]));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !reload_i) |=> $stable(rd_data));

  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (pos == '0) && (rd_data[0] == LEN_VAL[LEN_W-1]));

  a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_END) |-> (rd_data == 8'h00));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:1] == 7'b0);
endmodule

// File: tb/tb_serial_id_reader.sv
module tb_serial_id_reader;
  localparam int ID_W = 57;
  localparam int LEN_W = 8;
  localparam int TOT = ID_W + LEN_W;

  logic clk = 0;
  logic rst_n = 0;
  logic [ID_W-1:0] id_in = '0;
  logic rd_i = 0, reload_i = 0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  int mpos = 0;
  logic [ID_W-1:0] msnap = '0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_id_reader #(.ID_W(ID_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .id_in(id_in), .rd_i(rd_i),
    .reload_i(reload_i), .rd_data(rd_data));

  function automatic logic exp_bit(int k, logic [ID_W-1:0] s);
    logic [7:0] len = 8'(ID_W);
    if (k < LEN_W) return len[LEN_W-1-k];
    if (k < TOT) return s[ID_W-1-(k-LEN_W)];
    return 1'b0;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (pos %0d)", req, act, exp, mpos);
    end
  endtask

  task automatic step(logic rd, logic rl, string req);
    @(negedge clk);
    check(req, rd_data, {7'b0, exp_bit(mpos, msnap)});
    rd_i = rd; reload_i = rl;
    @(posedge clk);
    if (rl) begin mpos = 0; msnap = id_in; end
    else if (rd && mpos < TOT) mpos++;
    #1 rd_i = 0; reload_i = 0;
  endtask

  task automatic full_readout(string tag);
    logic [7:0] len = 0;
    logic [ID_W-1:0] val = 0;
    for (int i = 0; i < LEN_W; i++) begin
      @(negedge clk); len = {len[6:0], rd_data[0]};
      step(1, 0, "R2");
    end
    check({"R2 ", tag}, len, 8'(ID_W));
    for (int i = 0; i < ID_W; i++) begin
      @(negedge clk); val = {val[ID_W-2:0], rd_data[0]};
      id_in = {$urandom, $urandom};
      step(1, 0, "R3");
    end
    checks++;
    if (val !== msnap) begin
      fails++;
      $display("FAIL R3/R8 %s: got %h expected %h", tag, val, msnap);
    end
    for (int i = 0; i < 5; i++) step(1, 0, "R7");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    id_in = 57'h1A2_B3C4_D5E6_F708;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", rd_data, 8'h00);
    msnap = id_in; mpos = 0;
    @(negedge clk); rst_n = 1;
    check("R1 after reset", rd_data, {7'b0, exp_bit(0, msnap)});
    full_readout("after reset");
    step(0, 0, "R7 idle tail");
    id_in = {ID_W{1'b1}};
    step(1, 1, "R6 read+reload");
    full_readout("ones");
    id_in = 57'h0_0000_0000_0001;
    step(0, 1, "R6 reload");
    full_readout("single lsb");
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 3) == 0) id_in = {$urandom, $urandom};
      if (r < 2) step(1, 1, "R6 rand");
      else if (r < 4) step(0, 1, "R6 rand");
      else if (r < 70) step(1, 0, "R5 rand");
      else step(0, 0, "R5 hold");
      checks++;
      if (rd_data[7:1] !== 7'b0) begin
        fails++;
        $display("FAIL R4: got %h expected %h", rd_data, 8'h00);
      end
    end
    rst_n = 0; id_in = 57'h0F0_F0F0_0F0F_0F0F;
    @(posedge clk); msnap = id_in; mpos = 0;
    #1 rst_n = 1;
    full_readout("second reset R1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #400000; fails++; checks++; $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule